// File: doc/BRIEF.md
# Vector-Slot Input Data Buffer

This block holds the input data vectors of one neural-network stage until the error for each vector has come back and been used to update the taps. Storage is a synchronous RAM on the stage clock. Each vector of `VEC_LEN` samples is written into its own slot. The slot stride is the next power of two at or above `VEC_LEN`, so a word address is the slot index with the element index appended below it. There is no adder in any address path. When a vector's last sample has been accepted, the block writes zeros into the unused tail of its slot. Every element of a slot therefore reads back with a defined value, and padding elements read as zero.

A producer streams samples in with a valid/ready handshake. Two independent read ports, one for the feedforward path and one for the tap update, each name a slot and an element. Each port returns one word per request with one cycle of latency. Slots are handed out in round-robin order. A release strobe from the error path frees the oldest occupied slot. When every slot holds a completed vector that has not been released, the write port stalls. A read of a slot that holds no completed vector returns zero and sets a sticky debug flag.

Top module: `vec_slot_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, `rd_err` is 0, and both read data outputs are 0.
- R2: A sample is taken on each clock edge where `in_valid` and `in_ready` are both 1. Successive samples of a vector go to elements 0..VEC_LEN-1 of one slot. Vectors go to slots 0,1,...,NUM_SLOTS-1 and then wrap back to 0. Element e of slot s sits at word address s*STRIDE+e, where STRIDE is 2^ceil(log2(VEC_LEN)).
- R3: After the last sample of a vector, `in_ready` is 0 for exactly STRIDE-VEC_LEN cycles. In those cycles elements VEC_LEN..STRIDE-1 of the slot are written with 0.
- R4: On each read port, a request (`*_rd_en`=1 with slot s and element e) makes the data output show the stored word one clock edge later. The output then holds that value until the next request on the same port.
- R5: The feedforward and update ports serve requests in the same cycle, independently of each other and of writes.
- R6: While NUM_SLOTS completed vectors are unreleased, `in_ready` is 0 and no sample is taken.
- R7: A `rel_strobe` pulse frees the oldest completed vector. A slot is freed only by release. After a release on a full buffer, `in_ready` is 1 in the next cycle, and a later read of the freed slot returns 0.
- R8: A `rel_strobe` pulse while no completed vector is held has no effect. The next NUM_SLOTS vectors are still accepted, and the buffer is then full.
- R9: A read request to a slot that holds no completed vector returns 0 and sets `rd_err`. `rd_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Producer has a sample on `in_data` |
| in_ready | output | 1 | Block takes the sample on this edge |
| in_data | input | DATA_W | Input sample |
| ff_rd_en | input | 1 | Feedforward read request |
| ff_slot | input | SLOT_W | Feedforward slot index |
| ff_elem | input | ELEM_W | Feedforward element index |
| ff_data | output | DATA_W | Feedforward read data, one cycle after request |
| up_rd_en | input | 1 | Update read request |
| up_slot | input | SLOT_W | Update slot index |
| up_elem | input | ELEM_W | Update element index |
| up_data | output | DATA_W | Update read data, one cycle after request |
| rel_strobe | input | 1 | Free the oldest completed vector |
| rd_err | output | 1 | Sticky flag: a read hit an unoccupied slot |

## Verification
A slip in the write pointer or the element counter appears as a wrong word on a read port. It shows in the sweep that follows the fill, at the first element whose address was mis-formed. A wrong occupancy count shows as `in_ready` being high or low at the wrong moment, one cycle after the completion or release that moved it, and the extra release with an empty buffer exposes an underflow. Missing padding or a stale valid bit shows as a nonzero word, or a cleared or early-set `rd_err`, on the very next read of that address.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  typedef enum logic {
    FILL_DATA = 1'b0,
    FILL_PAD  = 1'b1
  } fill_st_e;
endpackage

// File: rtl/vsb_alloc.sv
// Slot allocation, fill sequencing and release tracking.
module vsb_alloc
  import vsb_pkg::*;
#(
  parameter int VEC_LEN   = 5,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int ELEM_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     rel_strobe,
  output logic                     wr_en,
  output logic                     wr_zero,
  output logic [SLOT_W+ELEM_W-1:0] wr_addr,
  output logic [NUM_SLOTS-1:0]     slot_vld
);
  localparam int  STRIDE     = 1 << ELEM_W;
  localparam int  CNT_W      = $clog2(NUM_SLOTS + 1);
  localparam bit  PAD_NEEDED = (VEC_LEN < STRIDE);

  fill_st_e              state_q, state_d;
  logic [ELEM_W-1:0]     elem_q, elem_d;
  logic [SLOT_W-1:0]     wr_ptr_q, wr_ptr_d;
  logic [SLOT_W-1:0]     rel_ptr_q, rel_ptr_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [NUM_SLOTS-1:0]  vld_q, vld_d;

  logic room, accept, last_data, last_pad, done, release_ok;

  function automatic logic [SLOT_W-1:0] ptr_inc(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    room       = (cnt_q != CNT_W'(NUM_SLOTS));
    in_ready   = (state_q == FILL_DATA) && room;
    accept     = in_valid && in_ready;
    last_data  = (elem_q == ELEM_W'(VEC_LEN - 1));
    last_pad   = (elem_q == ELEM_W'(STRIDE - 1));
    wr_zero    = (state_q == FILL_PAD);
    wr_en      = accept || wr_zero;
    wr_addr    = {wr_ptr_q, elem_q};
    done       = (accept && last_data && !PAD_NEEDED) || (wr_zero && last_pad);
    release_ok = rel_strobe && (cnt_q != '0);
  end

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    case (state_q)
      FILL_DATA: begin
        if (accept) begin
          if (last_data) begin
            if (PAD_NEEDED) begin
              state_d = FILL_PAD;
              elem_d  = elem_q + 1'b1;
            end else begin
              elem_d  = '0;
            end
          end else begin
            elem_d = elem_q + 1'b1;
          end
        end
      end
      default: begin
        if (last_pad) begin
          state_d = FILL_DATA;
          elem_d  = '0;
        end else begin
          elem_d  = elem_q + 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    wr_ptr_d  = done ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rel_ptr_d = release_ok ? ptr_inc(rel_ptr_q) : rel_ptr_q;
    case ({done, release_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    vld_d = vld_q;
    if (done)       vld_d[wr_ptr_q]  = 1'b1;
    if (release_ok) vld_d[rel_ptr_q] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FILL_DATA;
      elem_q    <= '0;
      wr_ptr_q  <= '0;
      rel_ptr_q <= '0;
      cnt_q     <= '0;
      vld_q     <= '0;
    end else begin
      state_q   <= state_d;
      elem_q    <= elem_d;
      wr_ptr_q  <= wr_ptr_d;
      rel_ptr_q <= rel_ptr_d;
      cnt_q     <= cnt_d;
      vld_q     <= vld_d;
    end
  end

  assign slot_vld = vld_q;
endmodule

// File: rtl/vsb_ram.sv
// One-write one-read synchronous RAM with registered, held read data.
module vsb_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vsb_rdport.sv
// One read port: private RAM copy, occupancy check, zero gating.
module vsb_rdport #(
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int ELEM_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SLOT_W+ELEM_W-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_SLOTS-1:0]     slot_vld,
  input  logic                     rd_en,
  input  logic [SLOT_W-1:0]        slot,
  input  logic [ELEM_W-1:0]        elem,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     miss
);
  localparam int ADDR_W = SLOT_W + ELEM_W;

  logic [DATA_W-1:0] ram_q;
  logic              hit, ok_q, ok_d;

  vsb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .re    (rd_en),
    .raddr ({slot, elem}),
    .rdata (ram_q)
  );

  always_comb begin
    hit  = slot_vld[slot];
    miss = rd_en && !hit;
    ok_d = rd_en ? hit : ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign rd_data = ok_q ? ram_q : '0;
endmodule

// File: rtl/vec_slot_buffer.sv
module vec_slot_buffer #(
  parameter int DATA_W    = 16,
  parameter int VEC_LEN   = 5,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int ELEM_W    = $clog2(VEC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ff_rd_en,
  input  logic [SLOT_W-1:0] ff_slot,
  input  logic [ELEM_W-1:0] ff_elem,
  output logic [DATA_W-1:0] ff_data,
  input  logic              up_rd_en,
  input  logic [SLOT_W-1:0] up_slot,
  input  logic [ELEM_W-1:0] up_elem,
  output logic [DATA_W-1:0] up_data,
  input  logic              rel_strobe,
  output logic              rd_err
);
  localparam int ADDR_W = SLOT_W + ELEM_W;
  localparam int NPORT  = 2;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                 wr_en, wr_zero;
  logic [ADDR_W-1:0]    wr_addr;
  logic [DATA_W-1:0]    wr_data;
  logic [NUM_SLOTS-1:0] slot_vld;

  vsb_alloc #(
    .VEC_LEN(VEC_LEN), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ELEM_W(ELEM_W)
  ) alloc_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .rel_strobe (rel_strobe),
    .wr_en      (wr_en),
    .wr_zero    (wr_zero),
    .wr_addr    (wr_addr),
    .slot_vld   (slot_vld)
  );

  assign wr_data = wr_zero ? '0 : in_data;

  logic [NPORT-1:0]             p_en, p_miss;
  logic [NPORT-1:0][SLOT_W-1:0] p_slot;
  logic [NPORT-1:0][ELEM_W-1:0] p_elem;
  logic [NPORT-1:0][DATA_W-1:0] p_data;

  assign p_en   = {up_rd_en, ff_rd_en};
  assign p_slot = {up_slot, ff_slot};
  assign p_elem = {up_elem, ff_elem};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    vsb_rdport #(
      .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ELEM_W(ELEM_W)
    ) port_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .we       (wr_en),
      .waddr    (wr_addr),
      .wdata    (wr_data),
      .slot_vld (slot_vld),
      .rd_en    (p_en[p]),
      .slot     (p_slot[p]),
      .elem     (p_elem[p]),
      .rd_data  (p_data[p]),
      .miss     (p_miss[p])
    );
  end

  assign ff_data = p_data[0];
  assign up_data = p_data[1];

  logic err_q, err_set;

  assign err_set = |p_miss;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign rd_err = err_q;
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 pad_busy,
  input logic [NUM_SLOTS-1:0] slot_vld,
  input logic                 ff_rd_en,
  input logic [SLOT_W-1:0]    ff_slot,
  input logic [DATA_W-1:0]    ff_data,
  input logic                 up_rd_en,
  input logic [SLOT_W-1:0]    up_slot,
  input logic [DATA_W-1:0]    up_data,
  input logic                 rd_err
);
  assert_no_accept_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ($countones(slot_vld) < NUM_SLOTS));

  assert_no_accept_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_busy |-> !in_ready);

  assert_ff_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_rd_en && !slot_vld[ff_slot]) |=> (ff_data == '0 && rd_err));

  assert_up_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rd_en && !slot_vld[up_slot]) |=> (up_data == '0 && rd_err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> rd_err);

  assert_ff_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_rd_en && $stable(slot_vld)) |=> $stable(ff_data));
endmodule

bind vec_slot_buffer vsb_checker #(
  .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .pad_busy (wr_zero),
  .slot_vld (slot_vld),
  .ff_rd_en (ff_rd_en),
  .ff_slot  (ff_slot),
  .ff_data  (ff_data),
  .up_rd_en (up_rd_en),
  .up_slot  (up_slot),
  .up_data  (up_data),
  .rd_err   (rd_err)
);

// File: tb/vec_slot_buffer_tb_top.sv
module vec_slot_buffer_tb_top;
  localparam int DW     = 16;
  localparam int K      = 5;
  localparam int NS     = 4;
  localparam int SW     = 2;
  localparam int EW     = 3;
  localparam int STRIDE = 8;

  logic          clk, rst_n;
  logic          in_valid, in_ready;
  logic [DW-1:0] in_data;
  logic          ff_rd_en, up_rd_en;
  logic [SW-1:0] ff_slot, up_slot;
  logic [EW-1:0] ff_elem, up_elem;
  logic [DW-1:0] ff_data, up_data;
  logic          rel_strobe, rd_err;

  vec_slot_buffer #(.DATA_W(DW), .VEC_LEN(K), .NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ff_rd_en(ff_rd_en), .ff_slot(ff_slot), .ff_elem(ff_elem), .ff_data(ff_data),
    .up_rd_en(up_rd_en), .up_slot(up_slot), .up_elem(up_elem), .up_data(up_data),
    .rel_strobe(rel_strobe), .rd_err(rd_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int exp_mem [NS][STRIDE];
  bit exp_vld [NS];
  int nxt_wr = 0;
  int nxt_rel = 0;
  int vid = 0;
  bit err_exp = 0;

  function automatic int sample_val(int v, int e);
    return (v * 16 + e + 1) & 16'hFFFF;
  endfunction

  function automatic int occupied();
    int n = 0;
    for (int s = 0; s < NS; s++) n += exp_vld[s];
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_vec(bit bubbles, output int pad_low);
    for (int e = 0; e < K; e++) begin
      @(negedge clk);
      if (bubbles && (e % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = DW'(sample_val(vid, e));
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    pad_low = 0;
    while (!in_ready && pad_low < 12) begin
      pad_low++;
      @(negedge clk);
    end
    for (int e = 0; e < STRIDE; e++)
      exp_mem[nxt_wr][e] = (e < K) ? sample_val(vid, e) : 0;
    exp_vld[nxt_wr] = 1'b1;
    nxt_wr = (nxt_wr + 1) % NS;
    vid++;
  endtask

  function automatic int exp_rd(int s, int e);
    return exp_vld[s] ? exp_mem[s][e] : 0;
  endfunction

  task automatic rd_pair(int fs, int fe, int us, int ue, string req);
    int fx, ux;
    @(negedge clk);
    ff_rd_en = 1'b1; ff_slot = SW'(fs); ff_elem = EW'(fe);
    up_rd_en = 1'b1; up_slot = SW'(us); up_elem = EW'(ue);
    fx = exp_rd(fs, fe);
    ux = exp_rd(us, ue);
    if (!exp_vld[fs] || !exp_vld[us]) err_exp = 1'b1;
    @(negedge clk);
    ff_rd_en = 1'b0;
    up_rd_en = 1'b0;
    chk({req, " ff"}, int'(ff_data), fx);
    chk({req, " up"}, int'(up_data), ux);
    chk("R9 rd_err", int'(rd_err), int'(err_exp));
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < STRIDE; e++)
        rd_pair(s, e, NS - 1 - s, STRIDE - 1 - e, req);
  endtask

  task automatic release_one();
    @(negedge clk);
    rel_strobe = 1'b1;
    @(negedge clk);
    rel_strobe = 1'b0;
    if (occupied() > 0) begin
      exp_vld[nxt_rel] = 1'b0;
      nxt_rel = (nxt_rel + 1) % NS;
    end
  endtask

  task automatic expect_stall(string req, int cycles);
    int low = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!in_ready) low++;
    end
    chk(req, low, cycles);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pl;
    for (int s = 0; s < NS; s++) exp_vld[s] = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0;
    ff_rd_en = 1'b0; ff_slot = '0; ff_elem = '0;
    up_rd_en = 1'b0; up_slot = '0; up_elem = '0;
    rel_strobe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 rd_err", int'(rd_err), 0);
    chk("R1 ff_data", int'(ff_data), 0);
    chk("R1 up_data", int'(up_data), 0);

    // R2 R3: fill three slots, with and without bubbles; padding stall length
    send_vec(1'b1, pl); chk("R3 pad stall v0", pl, STRIDE - K);
    send_vec(1'b0, pl); chk("R3 pad stall v1", pl, STRIDE - K);
    send_vec(1'b1, pl); chk("R3 pad stall v2", pl, STRIDE - K);
    send_vec(1'b0, pl);
    // R6: full, input stalled even with in_valid held high
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'hDEAD;
    expect_stall("R6 full stall", 6);
    in_valid = 1'b0;

    // R2 R3 R4 R5: full sweep, both ports at once with different addresses
    sweep("R2/R3/R5 sweep");

    // R4: output holds between requests
    rd_pair(2, 1, 1, 3, "R4 read");
    repeat (3) @(negedge clk);
    chk("R4 hold ff", int'(ff_data), exp_rd(2, 1));
    chk("R4 hold up", int'(up_data), exp_rd(1, 3));

    // R7: release on full buffer reopens input, freed slot reads zero
    release_one();
    chk("R7 ready after release", int'(in_ready), 1);
    rd_pair(0, 0, 1, 2, "R7/R9 freed slot");

    // R2: wrap to slot 0, buffer full again
    send_vec(1'b0, pl);
    chk("R6 full after wrap", int'(in_ready), 0);
    for (int e = 0; e < STRIDE; e++) rd_pair(0, e, 3, e, "R2 wrap slot0");

    // R8: drain, then an extra release with nothing held
    for (int i = 0; i < NS; i++) release_one();
    release_one();
    chk("R8 ready when empty", int'(in_ready), 1);
    for (int i = 0; i < NS - 1; i++) begin
      send_vec(i[0], pl);
      chk("R8 room remains", int'(in_ready), 1);
    end
    send_vec(1'b0, pl);
    chk("R8 full after NS vectors", int'(in_ready), 0);
    sweep("R2/R8 sweep after refill");
    chk("R9 sticky", int'(rd_err), 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule